// File: doc/BRIEF.md
# Interrupt Aggregation and Vector Encoder

This block collects four level-sensitive, active-low interrupt requests from the local side of a processor board: a serial port, the interrupt output of the host bridge, and two lines from an expansion module. It merges them into one interrupt for the processor. Alongside that interrupt it drives a four-bit, active-low vector code in which exactly one bit is low, naming the single source being served. A second merged interrupt goes back into the bridge. That one leaves out the bridge's own request so the bridge never loops its own interrupt back to itself.

Every request passes through a two-stage synchroniser. An enable mask then gates it, and a fixed-priority encoder picks the source to report. The mask comes out of reset with every source enabled and can be reloaded with a one-cycle write strobe. A separate non-maskable interrupt, active low, is raised while the bridge reports a local system error or asks the processor to back off the bus to break a dead-lock. The mask never touches this path. Requests are cleared by software at each source; this block holds no request state of its own.

Top module: `irq_vector_hub`

## Requirements
- R1: `cpu_irq` is high exactly when at least one source is both active and enabled. Active means its `src_req_n` bit is low; enabled means its mask bit is 1. Otherwise `cpu_irq` is low.
- R2: Each source has its own `cpu_vec_n` code. `src_req_n` bit 0 is the serial port and gives 4'b1101. Bit 1 is the bridge interrupt and gives 4'b1110. Bit 2 is expansion line 0 and gives 4'b1011. Bit 3 is expansion line 1 and gives 4'b0111. With no enabled source active the code is 4'b1111.
- R3: When several enabled sources are active, the code is that of the winner only. The priority is bit 0 first, then bit 1, then bit 2, then bit 3. At most one bit of `cpu_vec_n` is ever low.
- R4: `bridge_irq_n` is low exactly when an enabled source at bit 0, bit 2 or bit 3 is active. The bridge's own request (bit 1) never drives it.
- R5: `nmi_n` is low exactly when `bus_err_n` is low or `backoff_req` is high. The mask has no effect on it.
- R6: A cycle with `mask_wr` high loads `mask_data` into the enable mask. Mask bit i set to 0 removes source i from `cpu_irq`, `cpu_vec_n` and `bridge_irq_n`. Reset sets the mask to 4'b1111.
- R7: During and after reset, with no clock edge since, the outputs are idle: `cpu_irq`=0, `cpu_vec_n`=4'b1111, `bridge_irq_n`=1 and `nmi_n`=1. An input change is first visible at the outputs after the third rising edge (two synchroniser flops plus one output register).
- R8: Requests are levels. An output stays asserted for as long as its request is held and returns to idle three edges after the request is released, with nothing latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req_n | input | 4 | Raw interrupt requests, active low: bit 0 serial port, bit 1 bridge, bit 2 expansion 0, bit 3 expansion 1 |
| mask_wr | input | 1 | Load strobe for the enable mask |
| mask_data | input | 4 | New enable mask, 1 enables the source at the same bit |
| bus_err_n | input | 1 | Bridge local system error, active low |
| backoff_req | input | 1 | Bridge back-off request, active high |
| cpu_irq | output | 1 | Merged interrupt to the processor, active high |
| cpu_vec_n | output | 4 | Vector code of the served source, active low, one-cold |
| bridge_irq_n | output | 1 | Merged interrupt back into the bridge, active low |
| nmi_n | output | 1 | Non-maskable interrupt, active low |

## Verification
The bench drives two, three and four requests at once to confirm the vector shows only the highest-priority winner. A wrong priority chain would instead show a lower source, or more than one low bit. It sets a request from the bridge alone and checks that the feedback line stays idle. A design that fed all four sources back would raise `bridge_irq_n` there and hand the bridge its own interrupt. The bench uses masks that disable the winning source or every source, and confirms both that the next source takes over and that the non-maskable path still fires; a mask wired into the wrong path would silence a bus error. The bench also counts edges from a single request change to pin down the three-edge latency. A missing or extra synchroniser stage shows up one edge early or one edge late.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int NUM_SRC = 4;
    localparam int VEC_W   = 4;

    localparam int SRC_UART   = 0;
    localparam int SRC_BRIDGE = 1;
    localparam int SRC_EXP0   = 2;
    localparam int SRC_EXP1   = 3;

    localparam logic [VEC_W-1:0] VEC_IDLE = '1;

    // Sources that may be reported back into the bridge (own request excluded)
    localparam logic [NUM_SRC-1:0] FEEDBACK_SEL = ~(NUM_SRC'(1) << SRC_BRIDGE);

    // One-cold vector code per source index
    function automatic logic [VEC_W-1:0] vec_code(input int idx);
        case (idx)
            SRC_UART:   return 4'b1101;
            SRC_BRIDGE: return 4'b1110;
            SRC_EXP0:   return 4'b1011;
            SRC_EXP1:   return 4'b0111;
            default:    return VEC_IDLE;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               irq;
        logic               fb_irq_n;
        logic               nmi_n;
        logic [VEC_W-1:0]   vec_n;
    } hub_state_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_hub_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output logic [VEC_W-1:0]   vec_n,
    output logic               any
);

    logic [NUM_SRC:0]              blocked;
    logic [NUM_SRC-1:0]            won;
    logic [NUM_SRC-1:0][VEC_W-1:0] part;

    assign blocked[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign won[g]       = req[g] & ~blocked[g];
        assign blocked[g+1] = blocked[g] | req[g];
        assign part[g]      = won[g] ? vec_code(g) : VEC_IDLE;
    end

    always_comb begin
        vec_n = VEC_IDLE;
        for (int i = 0; i < NUM_SRC; i++) begin
            vec_n = vec_n & part[i];
        end
    end

    assign any = blocked[NUM_SRC];

endmodule

// File: rtl/irq_vector_hub.sv
module irq_vector_hub
    import irq_hub_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req_n,
    input  logic               mask_wr,
    input  logic [NUM_SRC-1:0] mask_data,
    input  logic               bus_err_n,
    input  logic               backoff_req,
    output logic               cpu_irq,
    output logic [VEC_W-1:0]   cpu_vec_n,
    output logic               bridge_irq_n,
    output logic               nmi_n
);

    localparam int SYNC_W  = NUM_SRC + 2;
    localparam int ERR_BIT = NUM_SRC;
    localparam int BO_BIT  = NUM_SRC + 1;

    localparam hub_state_t RESET_STATE = '{
        mask:     '1,
        irq:      1'b0,
        fb_irq_n: 1'b1,
        nmi_n:    1'b1,
        vec_n:    VEC_IDLE
    };

    hub_state_t state_d, state_q;

    logic [SYNC_W-1:0]  raw_act;
    logic [SYNC_W-1:0]  sync_act;
    logic [NUM_SRC-1:0] gated;
    logic [VEC_W-1:0]   win_vec_n;
    logic               win_any;

    // Convert everything to active-high before synchronising so that the
    // synchroniser reset value means "nothing pending".
    assign raw_act = {backoff_req, ~bus_err_n, ~src_req_n};

    irq_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_act),
        .dout  (sync_act)
    );

    assign gated = sync_act[NUM_SRC-1:0] & state_q.mask;

    irq_prio_enc u_prio (
        .req   (gated),
        .vec_n (win_vec_n),
        .any   (win_any)
    );

    always_comb begin
        state_d          = state_q;
        state_d.mask     = mask_wr ? mask_data : state_q.mask;
        state_d.irq      = win_any;
        state_d.vec_n    = win_vec_n;
        state_d.fb_irq_n = ~|(gated & FEEDBACK_SEL);
        state_d.nmi_n    = ~(sync_act[ERR_BIT] | sync_act[BO_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_irq      = state_q.irq;
    assign cpu_vec_n    = state_q.vec_n;
    assign bridge_irq_n = state_q.fb_irq_n;
    assign nmi_n        = state_q.nmi_n;

endmodule

// File: rtl/irq_vector_hub_chk.sv
module irq_vector_hub_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] src_req_n,
    input logic       bus_err_n,
    input logic       backoff_req,
    input logic       cpu_irq,
    input logic [3:0] cpu_vec_n,
    input logic       bridge_irq_n,
    input logic       nmi_n
);

    // Edges seen since reset release, saturating; gates the $past checks.
    logic [2:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (settle_q != 3'd7) begin
            settle_q <= settle_q + 3'd1;
        end
    end

    AST_VEC_ONE_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cpu_vec_n) <= 1); // R3

    AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (cpu_vec_n != 4'hF)); // R1

    AST_FEEDBACK_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_irq_n |-> cpu_irq); // R4

    AST_UART_WIN_FEEDS_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_vec_n[1] |-> !bridge_irq_n); // R4

    AST_NMI_TRACKS_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q >= 3'd3) |->
            (nmi_n == !(!$past(bus_err_n, 3) || $past(backoff_req, 3)))); // R5

    AST_IDLE_INPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((settle_q >= 3'd3) && ($past(src_req_n, 3) == 4'hF)) |-> !cpu_irq); // R8

endmodule

bind irq_vector_hub irq_vector_hub_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_req_n    (src_req_n),
    .bus_err_n    (bus_err_n),
    .backoff_req  (backoff_req),
    .cpu_irq      (cpu_irq),
    .cpu_vec_n    (cpu_vec_n),
    .bridge_irq_n (bridge_irq_n),
    .nmi_n        (nmi_n)
);

// File: tb/irq_vector_hub_test.sv
`timescale 1ns/1ps
module irq_vector_hub_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_req_n = 4'hF;
    logic       mask_wr = 1'b0;
    logic [3:0] mask_data = 4'hF;
    logic       bus_err_n = 1'b1;
    logic       backoff_req = 1'b0;
    logic       cpu_irq;
    logic [3:0] cpu_vec_n;
    logic       bridge_irq_n;
    logic       nmi_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_vector_hub uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_req_n    (src_req_n),
        .mask_wr      (mask_wr),
        .mask_data    (mask_data),
        .bus_err_n    (bus_err_n),
        .backoff_req  (backoff_req),
        .cpu_irq      (cpu_irq),
        .cpu_vec_n    (cpu_vec_n),
        .bridge_irq_n (bridge_irq_n),
        .nmi_n        (nmi_n)
    );

    // Row: mask[16:13] src_n[12:9] err_n[8] backoff[7] | vec_n[6:3] irq[2] br_n[1] nmi_n[0]
    localparam int ROWS = 15;
    localparam logic [16:0] TBL [ROWS] = '{
        {4'hF, 4'hF,    1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1},  // idle            R2
        {4'hF, 4'hE,    1'b1, 1'b0, 4'hD, 1'b1, 1'b0, 1'b1},  // serial          R2
        {4'hF, 4'hD,    1'b1, 1'b0, 4'hE, 1'b1, 1'b1, 1'b1},  // bridge alone    R4
        {4'hF, 4'hB,    1'b1, 1'b0, 4'hB, 1'b1, 1'b0, 1'b1},  // exp0            R2
        {4'hF, 4'h7,    1'b1, 1'b0, 4'h7, 1'b1, 1'b0, 1'b1},  // exp1            R2
        {4'hF, 4'h0,    1'b1, 1'b0, 4'hD, 1'b1, 1'b0, 1'b1},  // all             R3
        {4'hF, 4'b1001, 1'b1, 1'b0, 4'hE, 1'b1, 1'b0, 1'b1},  // bridge+exp0     R3
        {4'hF, 4'b0011, 1'b1, 1'b0, 4'hB, 1'b1, 1'b0, 1'b1},  // exp0+exp1       R3
        {4'hE, 4'h0,    1'b1, 1'b0, 4'hE, 1'b1, 1'b0, 1'b1},  // serial masked   R6
        {4'hD, 4'hD,    1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1},  // bridge masked   R6
        {4'h1, 4'b0001, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1},  // only serial en  R6
        {4'hF, 4'hF,    1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0},  // bus error       R5
        {4'hF, 4'hF,    1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0},  // back-off        R5
        {4'h0, 4'h0,    1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0},  // all masked      R5
        {4'h2, 4'h0,    1'b1, 1'b0, 4'hE, 1'b1, 1'b1, 1'b1}   // bridge only en  R4
    };

    task automatic check(input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic check_all(input logic [3:0] vec, input logic irq,
                             input logic brn, input logic nmi);
        check("R2 R3 cpu_vec_n", cpu_vec_n, vec);
        check("R1 R6 cpu_irq", {3'b0, cpu_irq}, {3'b0, irq});
        check("R4 bridge_irq_n", {3'b0, bridge_irq_n}, {3'b0, brn});
        check("R5 nmi_n", {3'b0, nmi_n}, {3'b0, nmi});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n       = 1'b0;
        src_req_n   = 4'hF;
        mask_wr     = 1'b0;
        bus_err_n   = 1'b1;
        backoff_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R7 reset state while reset is held
        check_all(4'hF, 1'b0, 1'b1, 1'b1);
        do_reset();
        check_all(4'hF, 1'b0, 1'b1, 1'b1);   // R7

        // Table walk
        for (int i = 0; i < ROWS; i++) begin
            @(negedge clk);
            mask_wr   = 1'b1;
            mask_data = TBL[i][16:13];
            @(negedge clk);
            mask_wr     = 1'b0;
            src_req_n   = TBL[i][12:9];
            bus_err_n   = TBL[i][8];
            backoff_req = TBL[i][7];
            repeat (5) @(negedge clk);
            check_all(TBL[i][6:3], TBL[i][2], TBL[i][1], TBL[i][0]);
        end

        // R6: mask returns to all-enabled after reset
        do_reset();
        src_req_n = 4'h7;     // expansion 1 only
        repeat (5) @(negedge clk);
        check("R6 reset mask exp1 vec", cpu_vec_n, 4'h7);

        // R7 latency: exp0 change seen after the third edge, not the second
        do_reset();
        repeat (4) @(negedge clk);
        src_req_n = 4'hB;
        repeat (2) @(negedge clk);
        check("R7 latency two edges irq", {3'b0, cpu_irq}, 4'h0);
        check("R7 latency two edges vec", cpu_vec_n, 4'hF);
        @(negedge clk);
        check("R7 latency third edge irq", {3'b0, cpu_irq}, 4'h1);
        check("R7 latency third edge vec", cpu_vec_n, 4'hB);

        // R8 level hold and release
        repeat (20) @(negedge clk);
        check("R8 held level vec", cpu_vec_n, 4'hB);
        src_req_n = 4'hF;
        repeat (2) @(negedge clk);
        check("R8 release not yet", {3'b0, cpu_irq}, 4'h1);
        @(negedge clk);
        check("R8 release irq", {3'b0, cpu_irq}, 4'h0);
        check("R8 release vec", cpu_vec_n, 4'hF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule